// File: doc/BRIEF.md
# Cascaded Second-Order IIR Filter Engine

This block filters one real 16-bit sample per request through a chain of up to `MAX_SECT` second-order recursive sections. All sections share a single multiply-accumulate datapath. A start pulse carries the number of sections, the size fields of the input and output circular buffers and the base addresses of both buffers. The engine fetches the next input sample from the input buffer. It then walks every section in turn, pulling six coefficients per section from a coefficient RAM in which the sets lie back to back. A final gain is applied once, and the result goes to the next slot of the output buffer.

Each section holds two delayed intermediate values (w1, w2) in an internal register file indexed by section number. These values survive between samples and are zeroed by reset or by a clear input. Arithmetic is Q15 with a 40-bit accumulator. The intermediate value, each section result and the final output are rounded and saturated to 16 bits.

For section s, coefficient k sits at index 6s+k. Roles:

- k=0 scales the section input.
- k=2 and k=3 are the feedback taps on w1 and w2.
- k=4 and k=5 are the feedforward taps on w1 and w2.
- k=1 is the output gain. Only the last section's k=1 is used.

Top module: `biquad_cascade`

## Requirements
- R1: While idle, a start pulse is accepted and `busy` is high from the next cycle until the sample completes. A start raised while `busy` is high is ignored: it causes no extra input read, no extra output write and no change to the parameters of the sample in flight.
- R2: Coefficient reads for section s use index 6s+k. Within a section they come in the order k=0,2,3,4,5, one per cycle, with a read latency of one cycle. The gain k=1 of the last section is read once, after the last section.
- R3: Each section computes w = rs(C0·x + C2·w1 + C3·w2) and y = rs(w·2^15 + C4·w1 + C5·w2), where x is the section input. It then sets w2←w1 and w1←w. The first section's x is the input sample, and each later section's x is the previous section's y.
- R4: The output is rs(C1·y) with the last section's C1 and the last section's y. The C1 entries of earlier sections have no effect on the output.
- R5: rs(a) adds 2^14, shifts right arithmetically by 15 and saturates to the range [-32768, 32767].
- R6: Each section's delay state is independent. Pulsing `clearState` zeroes all of them, so the next sample behaves as if from reset, while the buffer offsets are kept.
- R7: The input read address is `inBase` plus an offset. The offset is 0 after reset. After each sample it becomes offset+2, or 0 if offset+2 exceeds `mSize`.
- R8: The output write address is the latched `outBase` plus an offset that follows the same rule with `nSize`.
- R9: `outWrEn` is high for one cycle, exactly 5S+3 cycles after the accepted start cycle, where S is the effective section count. `done` is a one-cycle pulse in the following cycle.
- R10: An `iterCount` of 0 is treated as 1, and a value above `MAX_SECT` is treated as `MAX_SECT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Request to process one sample |
| iterCount | input | $clog2(MAX_SECT)+1 | Number of cascaded sections |
| mSize | input | ADDR_W | Input buffer size in bytes minus one |
| nSize | input | ADDR_W | Output buffer size in bytes minus one |
| inBase | input | ADDR_W | Input buffer base byte address |
| outBase | input | ADDR_W | Output buffer base byte address |
| clearState | input | 1 | Zero all section delay state |
| busy | output | 1 | Sample in progress |
| done | output | 1 | One-cycle pulse after the output write |
| inRdEn | output | 1 | Input sample read strobe |
| inAddr | output | ADDR_W | Input sample byte address |
| inData | input | 16 | Input sample, valid the cycle after inRdEn |
| coefRdEn | output | 1 | Coefficient read strobe |
| coefAddr | output | $clog2(6*MAX_SECT) | Coefficient index |
| coefData | input | 16 | Coefficient, valid the cycle after coefRdEn |
| outWrEn | output | 1 | Output write strobe |
| outAddr | output | ADDR_W | Output byte address |
| outData | output | 16 | Filtered output sample |

## Verification
Delay state is carried from sample to sample, so a corrupted w1 or w2 shows up as a wrong `outData`. In a multi-section chain it can show up in the sample after the error or several samples later. The bench therefore compares every output of long random runs against a reference model that keeps its own state. A wrong buffer offset appears at the first address that should have wrapped. A sequencing fault shifts the `outWrEn` and `done` cycle against the 5S+3 count, or drops a coefficient product, which changes the very next output.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W = 40;
  localparam int PROD_W = 2 * DATA_W;
  localparam int FRAC_W = DATA_W - 1;
  localparam int COEFS_PER_SECT = 6;

  typedef enum logic [1:0] {OPR_XIN, OPR_PREV, OPR_W1, OPR_W2} opr_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_WRITE} ctl_state_e;

  typedef struct packed {
    logic mac;
    logic clr;
    logic addW;
    logic updSt;
    opr_e opr;
  } mac_cmd_t;

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [ACC_W-1:0] a);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);
    logic signed [ACC_W-1:0] t;
    t = (a + ACC_W'(2 ** (FRAC_W - 1))) >>> FRAC_W;
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/biquad_ctrl.sv
module biquad_ctrl
  import biquad_pkg::*;
#(
  parameter int MAX_SECT = 4,
  parameter int ADDR_W = 16,
  localparam int CNT_W = $clog2(MAX_SECT) + 1,
  localparam int SECT_W = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1,
  localparam int CIDX_W = $clog2(MAX_SECT * COEFS_PER_SECT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  iterCount,
  input  logic [ADDR_W-1:0] mSize,
  input  logic [ADDR_W-1:0] nSize,
  input  logic [ADDR_W-1:0] inBase,
  input  logic [ADDR_W-1:0] outBase,
  output logic              busy,
  output logic              done,
  output logic              inRdEn,
  output logic [ADDR_W-1:0] inAddr,
  output logic              coefRdEn,
  output logic [CIDX_W-1:0] coefAddr,
  output logic              outWrEn,
  output logic [ADDR_W-1:0] outAddr,
  output logic              loadX,
  output mac_cmd_t          cmd,
  output logic [SECT_W-1:0] cmdSect
);
  ctl_state_e state;
  logic [SECT_W-1:0] sect, lastSect, lastNew;
  logic [2:0] step, kSel;
  logic [ADDR_W-1:0] nSizeQ, outBaseQ, inOff, outOff;

  function automatic logic [ADDR_W-1:0] wrapStep(input logic [ADDR_W-1:0] off,
                                                 input logic [ADDR_W-1:0] size);
    logic [ADDR_W:0] n;
    n = {1'b0, off} + (ADDR_W+1)'(2);
    return (n > {1'b0, size}) ? '0 : n[ADDR_W-1:0];
  endfunction

  always_comb begin
    if (iterCount == '0) lastNew = '0;
    else if (iterCount > CNT_W'(MAX_SECT)) lastNew = SECT_W'(MAX_SECT - 1);
    else lastNew = SECT_W'(iterCount - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sect     <= '0;
      step     <= '0;
      lastSect <= '0;
      nSizeQ   <= '0;
      outBaseQ <= '0;
      inOff    <= '0;
      outOff   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          lastSect <= lastNew;
          nSizeQ   <= nSize;
          outBaseQ <= outBase;
          inOff    <= wrapStep(inOff, mSize);
          sect     <= '0;
          step     <= '0;
          state    <= ST_RUN;
        end
        ST_RUN: begin
          if (step == 3'd5) state <= ST_DRAIN;
          else if (step == 3'd4) begin
            if (sect == lastSect) step <= 3'd5;
            else begin
              sect <= sect + SECT_W'(1);
              step <= 3'd0;
            end
          end else step <= step + 3'd1;
        end
        ST_DRAIN: state <= ST_WRITE;
        default: begin
          outOff <= wrapStep(outOff, nSizeQ);
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (step)
      3'd0: kSel = 3'd0;
      3'd1: kSel = 3'd2;
      3'd2: kSel = 3'd3;
      3'd3: kSel = 3'd4;
      3'd4: kSel = 3'd5;
      default: kSel = 3'd1;
    endcase
  end

  always_comb begin
    cmd = '0;
    if (state == ST_RUN) begin
      cmd.mac = 1'b1;
      case (step)
        3'd0: begin cmd.clr = 1'b1; cmd.opr = (sect == '0) ? OPR_XIN : OPR_PREV; end
        3'd1: cmd.opr = OPR_W1;
        3'd2: cmd.opr = OPR_W2;
        3'd3: begin cmd.opr = OPR_W1; cmd.addW = 1'b1; end
        3'd4: begin cmd.opr = OPR_W2; cmd.updSt = 1'b1; end
        default: begin cmd.opr = OPR_PREV; cmd.clr = 1'b1; end
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign inRdEn   = (state == ST_IDLE) && start;
  assign inAddr   = inBase + inOff;
  assign coefRdEn = (state == ST_RUN);
  assign coefAddr = CIDX_W'(sect) * CIDX_W'(COEFS_PER_SECT) + CIDX_W'(kSel);
  assign outWrEn  = (state == ST_WRITE);
  assign outAddr  = outBaseQ + outOff;
  assign loadX    = (state == ST_RUN) && (sect == '0) && (step == 3'd0);
  assign cmdSect  = sect;
endmodule

// File: rtl/biquad_dp.sv
module biquad_dp
  import biquad_pkg::*;
#(
  parameter int MAX_SECT = 4,
  localparam int SECT_W = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearState,
  input  logic              loadX,
  input  logic [DATA_W-1:0] inData,
  input  mac_cmd_t          cmd,
  input  logic [SECT_W-1:0] cmdSect,
  input  logic [DATA_W-1:0] coefData,
  output logic [DATA_W-1:0] result
);
  mac_cmd_t cmdQ;
  logic [SECT_W-1:0] sectQ;
  logic signed [DATA_W-1:0] xReg, wReg, satAcc, oper, coefS;
  logic signed [DATA_W-1:0] st1 [MAX_SECT];
  logic signed [DATA_W-1:0] st2 [MAX_SECT];
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0] acc, baseV, prodExt, wExt;

  // command stage lines up with the one-cycle coefficient read latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      sectQ <= '0;
      xReg  <= '0;
    end else begin
      cmdQ  <= cmd;
      sectQ <= cmdSect;
      if (loadX) xReg <= signed'(inData);
    end
  end

  assign satAcc = roundSat(acc);
  assign coefS  = signed'(coefData);

  always_comb begin
    case (cmdQ.opr)
      OPR_XIN:  oper = xReg;
      OPR_PREV: oper = satAcc;
      OPR_W1:   oper = st1[sectQ];
      default:  oper = st2[sectQ];
    endcase
  end

  assign prod    = oper * coefS;
  assign prodExt = ACC_W'(prod);
  assign wExt    = ACC_W'(satAcc) <<< FRAC_W;

  always_comb begin
    if (cmdQ.clr) baseV = '0;
    else if (cmdQ.addW) baseV = wExt;
    else baseV = acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      wReg <= '0;
    end else if (cmdQ.mac) begin
      acc <= baseV + prodExt;
      if (cmdQ.addW) wReg <= satAcc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearState) begin
      for (int i = 0; i < MAX_SECT; i++) begin
        st1[i] <= '0;
        st2[i] <= '0;
      end
    end else if (cmdQ.mac && cmdQ.updSt) begin
      st1[sectQ] <= wReg;
      st2[sectQ] <= st1[sectQ];
    end
  end

  assign result = satAcc;
endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
  import biquad_pkg::*;
#(
  parameter int MAX_SECT = 4,
  parameter int ADDR_W = 16,
  localparam int CNT_W = $clog2(MAX_SECT) + 1,
  localparam int SECT_W = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1,
  localparam int CIDX_W = $clog2(MAX_SECT * COEFS_PER_SECT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  iterCount,
  input  logic [ADDR_W-1:0] mSize,
  input  logic [ADDR_W-1:0] nSize,
  input  logic [ADDR_W-1:0] inBase,
  input  logic [ADDR_W-1:0] outBase,
  input  logic              clearState,
  output logic              busy,
  output logic              done,
  output logic              inRdEn,
  output logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              coefRdEn,
  output logic [CIDX_W-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output logic              outWrEn,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);
  mac_cmd_t cmd;
  logic [SECT_W-1:0] cmdSect;
  logic loadX;

  biquad_ctrl #(.MAX_SECT(MAX_SECT), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .iterCount(iterCount),
    .mSize(mSize), .nSize(nSize), .inBase(inBase), .outBase(outBase),
    .busy(busy), .done(done), .inRdEn(inRdEn), .inAddr(inAddr),
    .coefRdEn(coefRdEn), .coefAddr(coefAddr), .outWrEn(outWrEn),
    .outAddr(outAddr), .loadX(loadX), .cmd(cmd), .cmdSect(cmdSect)
  );

  biquad_dp #(.MAX_SECT(MAX_SECT)) i_dp (
    .clk(clk), .rstN(rstN), .clearState(clearState), .loadX(loadX),
    .inData(inData), .cmd(cmd), .cmdSect(cmdSect), .coefData(coefData),
    .result(outData)
  );
endmodule

// File: rtl/biquad_cascade_chk.sv
module biquad_cascade_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              inRdEn,
  input logic [ADDR_W-1:0] inAddr,
  input logic [ADDR_W-1:0] inBase,
  input logic [ADDR_W-1:0] outBase,
  input logic              coefRdEn,
  input logic              outWrEn,
  input logic [ADDR_W-1:0] outAddr
);
  logic haveIn, haveOut;
  logic [ADDR_W-1:0] prevIn, prevInBase, prevOut, prevOutBase, obQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveIn <= 1'b0; haveOut <= 1'b0;
      prevIn <= '0; prevInBase <= '0; prevOut <= '0; prevOutBase <= '0; obQ <= '0;
    end else begin
      if (start && !busy) obQ <= outBase;
      if (inRdEn) begin haveIn <= 1'b1; prevIn <= inAddr; prevInBase <= inBase; end
      if (outWrEn) begin haveOut <= 1'b1; prevOut <= outAddr; prevOutBase <= obQ; end
    end
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_in_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inRdEn && haveIn && inBase == prevInBase) |->
      (inAddr == prevIn + ADDR_W'(2) || inAddr == inBase));

  p_out_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outWrEn && haveOut && obQ == prevOutBase) |->
      (outAddr == prevOut + ADDR_W'(2) || outAddr == obQ));

  p_done_follows_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |=> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_quiet_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> (!coefRdEn && busy));
endmodule

bind biquad_cascade biquad_cascade_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .inRdEn(inRdEn), .inAddr(inAddr), .inBase(inBase), .outBase(outBase),
  .coefRdEn(coefRdEn), .outWrEn(outWrEn), .outAddr(outAddr)
);

// File: tb/test_biquad_cascade.sv
`timescale 1ns/1ps
module test_biquad_cascade;
  localparam int MAXS = 4;
  localparam int AW = 16;
  localparam int INB = 16;
  localparam int OUTB = 160;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, clearState = 1'b0;
  logic [2:0] iterCount = '0;
  logic [AW-1:0] mSize = '0, nSize = '0, inBase = AW'(INB), outBase = AW'(OUTB);
  logic busy, done, inRdEn, coefRdEn, outWrEn;
  logic [AW-1:0] inAddr, outAddr;
  logic [4:0] coefAddr;
  logic [15:0] inData = '0, coefData = '0, outData;

  logic signed [15:0] inMem [0:63];
  logic signed [15:0] coefMem [0:23];
  int nChecks = 0, nErr = 0, rdCnt = 0, wrCnt = 0;
  int lastRd = 0, lastWrAddr = 0, lastWrData = 0;
  int mW1 [MAXS], mW2 [MAXS];
  int mInOff = 0, mOutOff = 0;

  always #2.5 clk = ~clk;

  biquad_cascade #(.MAX_SECT(MAXS), .ADDR_W(AW)) i_biquad_cascade (
    .clk(clk), .rstN(rstN), .start(start), .iterCount(iterCount),
    .mSize(mSize), .nSize(nSize), .inBase(inBase), .outBase(outBase),
    .clearState(clearState), .busy(busy), .done(done), .inRdEn(inRdEn),
    .inAddr(inAddr), .inData(inData), .coefRdEn(coefRdEn), .coefAddr(coefAddr),
    .coefData(coefData), .outWrEn(outWrEn), .outAddr(outAddr), .outData(outData)
  );

  always @(posedge clk) begin
    if (inRdEn) begin inData <= inMem[inAddr[6:1]]; rdCnt++; lastRd = int'(inAddr); end
    if (coefRdEn) coefData <= coefMem[coefAddr];
    if (outWrEn) begin wrCnt++; lastWrAddr = int'(outAddr); lastWrData = int'($signed(outData)); end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rs(input longint a);
    longint t;
    t = (a + 64'sd16384) >>> 15;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return int'(t);
  endfunction

  function automatic int effCnt(input int c);
    if (c == 0) return 1;
    if (c > MAXS) return MAXS;
    return c;
  endfunction

  function automatic int wrapOff(input int off, input int sz);
    return (off + 2 > sz) ? 0 : off + 2;
  endfunction

  task automatic modelRun(input int x0, input int s, output int y);
    int x, w, yv, b;
    longint acc;
    x = x0;
    for (int i = 0; i < s; i++) begin
      b = 6 * i;
      acc = longint'(coefMem[b]) * x + longint'(coefMem[b+2]) * mW1[i] + longint'(coefMem[b+3]) * mW2[i];
      w = rs(acc);
      acc = longint'(w) * 32768 + longint'(coefMem[b+4]) * mW1[i] + longint'(coefMem[b+5]) * mW2[i];
      yv = rs(acc);
      mW2[i] = mW1[i];
      mW1[i] = w;
      x = yv;
    end
    y = rs(longint'(coefMem[6*(s-1)+1]) * x);
  endtask

  task automatic zeroModel();
    for (int i = 0; i < MAXS; i++) begin mW1[i] = 0; mW2[i] = 0; end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    zeroModel(); mInOff = 0; mOutOff = 0;
  endtask

  task automatic doClear();
    @(negedge clk); clearState = 1'b1;
    @(negedge clk); clearState = 1'b0;
    zeroModel();
  endtask

  task automatic setNextIn(input int v);
    inMem[((INB + mInOff) >> 1) % 64] = 16'(v);
  endtask

  // one sample; extra=1 raises a second start while busy
  task automatic runOne(input int cnt, input int m, input int n, input bit extra,
                        input string tag, output int outV);
    int s, x, expY, expIn, expOut, cyc, wrCyc, rd0, wr0;
    s = effCnt(cnt);
    expIn = INB + mInOff;
    expOut = OUTB + mOutOff;
    x = int'(inMem[(expIn >> 1) % 64]);
    modelRun(x, s, expY);
    mInOff = wrapOff(mInOff, m);
    mOutOff = wrapOff(mOutOff, n);
    rd0 = rdCnt; wr0 = wrCnt;
    @(negedge clk);
    start = 1'b1; iterCount = 3'(cnt); mSize = AW'(m); nSize = AW'(n);
    cyc = 0; wrCyc = -1;
    while (cyc < 400) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (extra && cyc == 3) begin start = 1'b1; iterCount = 3'd1; nSize = AW'(1); end
      if (outWrEn && wrCyc < 0) wrCyc = cyc;
      if (done) break;
    end
    start = 1'b0;
    chk(cyc == 5*s + 4, "R9", "done cycle", cyc, 5*s + 4);
    chk(wrCyc == 5*s + 3, "R9", "write cycle", wrCyc, 5*s + 3);
    chk(lastWrData == expY, tag, "output value", lastWrData, expY);
    chk(lastRd == expIn, "R7", "input address", lastRd, expIn);
    chk(lastWrAddr == expOut, "R8", "output address", lastWrAddr, expOut);
    if (extra) begin
      repeat (3) @(negedge clk);
      chk(rdCnt - rd0 == 1, "R1", "reads per busy start", rdCnt - rd0, 1);
      chk(wrCnt - wr0 == 1, "R1", "writes per busy start", wrCnt - wr0, 1);
    end
    outV = lastWrData;
  endtask

  function automatic int rndCoef();
    return int'($urandom_range(0, 24000)) - 12000;
  endfunction

  initial begin
    int o1, o2, dummy, s;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) inMem[i] = 16'($urandom());
    for (int i = 0; i < 24; i++) coefMem[i] = 16'(rndCoef());
    zeroModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !outWrEn && !coefRdEn, "R1", "idle after reset",
        {busy, done, outWrEn, coefRdEn}, 0);

    // R3 single section, simple taps
    coefMem[0] = 16'sd16384; coefMem[1] = 16'sd32767; coefMem[2] = 16'sd8192;
    coefMem[3] = -16'sd4096; coefMem[4] = 16'sd12000; coefMem[5] = 16'sd3000;
    for (int k = 0; k < 4; k++) begin
      setNextIn(1000 * (k + 1));
      runOne(1, 31, 31, 1'b0, "R3", dummy);
    end

    // R5 saturation both ways
    coefMem[0] = 16'sd32767; coefMem[1] = 16'sd32767; coefMem[2] = 16'sd0;
    coefMem[3] = 16'sd0; coefMem[4] = 16'sd32767; coefMem[5] = 16'sd32767;
    doClear();
    setNextIn(32767); runOne(1, 31, 31, 1'b0, "R5", dummy);
    setNextIn(32767); runOne(1, 31, 31, 1'b0, "R5", dummy);
    chk(dummy == 32766, "R5", "positive clip", dummy, 32766);
    doClear();
    setNextIn(-32768); runOne(1, 31, 31, 1'b0, "R5", dummy);
    setNextIn(-32768); runOne(1, 31, 31, 1'b0, "R5", dummy);
    chk(dummy < -32700, "R5", "negative clip", dummy, -32767);

    // R4 earlier-section gain ignored; R6 clear restarts state
    for (int i = 0; i < 12; i++) coefMem[i] = 16'(rndCoef());
    coefMem[7] = 16'sd20000;
    doClear();
    setNextIn(5000); runOne(2, 31, 31, 1'b0, "R4", o1);
    setNextIn(-7000); runOne(2, 31, 31, 1'b0, "R6", dummy);
    coefMem[1] = -16'sd31000;
    doClear();
    setNextIn(5000); runOne(2, 31, 31, 1'b0, "R4", o2);
    chk(o1 == o2, "R4", "first-section gain effect", o2, o1);
    chk(o1 != 0, "R6", "nonzero reference", o1, 1);

    // R1 start while busy ignored
    runOne(3, 31, 31, 1'b1, "R1", dummy);

    // R10 clamp of section count
    runOne(0, 31, 31, 1'b0, "R10", dummy);
    runOne(7, 31, 31, 1'b0, "R10", dummy);

    // R7 R8 wrap with small buffers
    doReset();
    for (int k = 0; k < 7; k++) runOne(1, 5, 3, 1'b0, "R3", dummy);

    // random mix over all sections (R2 ordering shows in every value)
    doReset();
    for (int i = 0; i < 24; i++) coefMem[i] = 16'(rndCoef());
    for (int k = 0; k < 60; k++) begin
      s = int'($urandom_range(1, MAXS));
      if (k % 20 == 19) doClear();
      runOne(s, 9, 7, 1'b0, "R2", dummy);
    end

    summary();
    $finish;
  end
endmodule